// File: doc/BRIEF.md
# Modem Handshake Controller with Automatic Enables

This block handles the modem handshake for one serial channel. Two active-low modem inputs, clear-to-send and carrier-detect, are synchronized. Each of their transitions, rising or falling, is detected. Each input has its own enable for raising a status-change interrupt. While that interrupt is pending, the status bits hold the levels seen at the moment of the change. A clear strobe releases them.

A mode bit turns on automatic enabling. When it is on, the synchronized modem inputs gate the transmitter and the receiver directly. In asynchronous operation, request-to-send is then held active until the transmitter has fully drained. In bit-oriented synchronous operation, an option holds request-to-send until the closing flag has left the line.

The terminal-ready output has two functions. It can follow its control bit, or it can carry the transmitter DMA request. As a DMA request it releases either at once or after a fixed delay.

Top module: `modem_handshake`

## Requirements
- R1: Each modem pin passes through a two-stage synchronizer. `cts_status` and `dcd_status` are active high, where 1 means the pin is low. A pin change is reflected in its status bit on the third rising clock edge after the change, provided no interrupt is pending.
- R2: A change in either direction on an input whose interrupt enable is set raises `status_irq` on that same third edge. Both status bits then hold the levels latched at that edge until a clear, even if the pins change again.
- R3: A change on an input whose interrupt enable is clear raises no interrupt, but its status bit still follows the pin.
- R4: A `status_clr` pulse drops `status_irq` on the next edge, and the status bits take up the current levels again. If an enabled change falls on the same edge as the clear, the change wins: `status_irq` stays 1 and the new level is latched.
- R5: With `auto_en` clear, `tx_enable` and `rx_enable` are both 1, whatever the modem pins do.
- R6: With `auto_en` set, `tx_enable` is 1 exactly when the synchronized clear-to-send pin is low. `rx_enable` is 1 exactly when the synchronized carrier-detect pin is low. Each follows its pin two edges after a change.
- R7: With `auto_en` clear, and outside the synchronous flag-release option, `rts_n` equals the inverse of `rts_bit`, registered one edge later.
- R8: With `auto_en` set and `async_mode` = 1, clearing `rts_bit` keeps `rts_n` low until an edge at which `tx_empty` is 1. `rts_n` goes high on that edge.
- R9: With `async_mode` = 0 and `flag_release_en` set, clearing `rts_bit` keeps `rts_n` low until an edge at which `flag_done` is 1. `rts_n` goes high on that edge.
- R10: With `req_mode` = 0, `dtr_req_n` is the inverse of `dtr_bit`, registered one edge later, and `tx_dma_req` has no effect on it.
- R11: With `req_mode` = 1 and `req_delay_sel` = 0, `dtr_req_n` is the inverse of `tx_dma_req`, registered one edge later.
- R12: With `req_mode` = 1 and `req_delay_sel` = 1, `dtr_req_n` goes low one edge after `tx_dma_req` rises. After `tx_dma_req` falls, it goes high four edges later than it would under R11.
- R13: While `rst_n` is low, `rts_n` and `dtr_req_n` are 1, `status_irq` is 0, and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_n_pin | input | 1 | Raw clear-to-send pin, active low |
| dcd_n_pin | input | 1 | Raw carrier-detect pin, active low |
| auto_en | input | 1 | Automatic enable mode |
| async_mode | input | 1 | 1 = asynchronous, 0 = bit-oriented synchronous |
| flag_release_en | input | 1 | Hold request-to-send until the closing flag is out |
| rts_bit | input | 1 | Request-to-send control bit |
| dtr_bit | input | 1 | Terminal-ready control bit |
| req_mode | input | 1 | 1 = pin carries the DMA request |
| req_delay_sel | input | 1 | 1 = delayed DMA request release |
| tx_empty | input | 1 | Transmitter completely empty |
| flag_done | input | 1 | Strobe: closing flag has left the data pin |
| tx_dma_req | input | 1 | Transmitter DMA request source |
| ie_cts | input | 1 | Interrupt enable for clear-to-send changes |
| ie_dcd | input | 1 | Interrupt enable for carrier-detect changes |
| status_clr | input | 1 | Clear pending interrupt and unfreeze status |
| tx_enable | output | 1 | Transmitter enable |
| rx_enable | output | 1 | Receiver enable |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_req_n | output | 1 | Terminal-ready or DMA request pin, active low |
| cts_status | output | 1 | Latched clear-to-send status (1 = asserted) |
| dcd_status | output | 1 | Latched carrier-detect status (1 = asserted) |
| status_irq | output | 1 | Status-change interrupt request |

## Verification
The clear of a pending interrupt and a fresh enabled transition can reach the status logic on the same clock edge. A careless design would lose the new event there. To provoke the collision, carrier-detect first raises an interrupt. Clear-to-send is then toggled, and `status_clr` is driven so that the clear meets the second change exactly on the third edge after that toggle. The case is judged correct when `status_irq` stays set and `cts_status` shows the new level.

// File: rtl/modem_handshake.sv
module modem_handshake #(
  parameter int SYNC_STAGES = 2,
  parameter int REL_DELAY   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_pin,
  input  logic dcd_n_pin,
  input  logic auto_en,
  input  logic async_mode,
  input  logic flag_release_en,
  input  logic rts_bit,
  input  logic dtr_bit,
  input  logic req_mode,
  input  logic req_delay_sel,
  input  logic tx_empty,
  input  logic flag_done,
  input  logic tx_dma_req,
  input  logic ie_cts,
  input  logic ie_dcd,
  input  logic status_clr,
  output logic tx_enable,
  output logic rx_enable,
  output logic rts_n,
  output logic dtr_req_n,
  output logic cts_status,
  output logic dcd_status,
  output logic status_irq
);

  localparam int CNT_W = $clog2(REL_DELAY + 1);

  logic [SYNC_STAGES-1:0] cts_sync, dcd_sync;
  logic cts_s, dcd_s, cts_d, dcd_d;
  logic set_now;
  logic rts_q, rts_release;
  logic dtr_q;
  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_sync <= '1;
      dcd_sync <= '1;
      cts_d    <= 1'b1;
      dcd_d    <= 1'b1;
    end else begin
      cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n_pin};
      dcd_sync <= {dcd_sync[SYNC_STAGES-2:0], dcd_n_pin};
      cts_d    <= cts_s;
      dcd_d    <= dcd_s;
    end
  end

  assign cts_s   = cts_sync[SYNC_STAGES-1];
  assign dcd_s   = dcd_sync[SYNC_STAGES-1];
  assign set_now = (ie_cts & (cts_s ^ cts_d)) | (ie_dcd & (dcd_s ^ dcd_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_irq <= 1'b0;
      cts_status <= 1'b0;
      dcd_status <= 1'b0;
    end else begin
      if (status_clr)   status_irq <= set_now;
      else if (set_now) status_irq <= 1'b1;
      if (!status_irq || status_clr) begin
        cts_status <= ~cts_s;
        dcd_status <= ~dcd_s;
      end
    end
  end

  assign tx_enable = ~auto_en | ~cts_s;
  assign rx_enable = ~auto_en | ~dcd_s;

  assign rts_release = (auto_en & async_mode)          ? tx_empty  :
                       (~async_mode & flag_release_en) ? flag_done : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= rts_bit | (rts_q & ~rts_release);
  end

  assign rts_n = ~rts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtr_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (!req_mode) begin
      dtr_q    <= dtr_bit;
      hold_cnt <= '0;
    end else begin
      if (tx_dma_req)          hold_cnt <= CNT_W'(REL_DELAY);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      dtr_q <= tx_dma_req | (req_delay_sel & (hold_cnt != '0));
    end
  end

  assign dtr_req_n = ~dtr_q;

endmodule

// File: rtl/modem_handshake_chk.sv
module modem_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic async_mode,
  input logic flag_release_en,
  input logic rts_bit,
  input logic dtr_bit,
  input logic req_mode,
  input logic req_delay_sel,
  input logic tx_empty,
  input logic flag_done,
  input logic tx_dma_req,
  input logic status_clr,
  input logic tx_enable,
  input logic rx_enable,
  input logic rts_n,
  input logic dtr_req_n,
  input logic cts_status,
  input logic dcd_status,
  input logic status_irq
);

  assert_frozen_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_irq && !status_clr) |=> ($stable(cts_status) && $stable(dcd_status)));

  assert_irq_drop_by_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_irq) |-> $past(status_clr));

  assert_enables_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (tx_enable && rx_enable));

  assert_rts_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && (async_mode || !flag_release_en)) |=> (rts_n == !$past(rts_bit)));

  assert_rts_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && async_mode && !rts_n && !tx_empty) |=> !rts_n);

  assert_rts_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && flag_release_en && !rts_n && !flag_done) |=> !rts_n);

  assert_dtr_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_mode |=> (dtr_req_n == !$past(dtr_bit)));

  assert_req_prompt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode && !req_delay_sel && !tx_dma_req) |=> dtr_req_n);

  assert_req_assert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode && tx_dma_req) |=> !dtr_req_n);

endmodule

bind modem_handshake modem_handshake_chk u_chk (.*);

// File: tb/modem_handshake_bench.sv
`timescale 1ns/1ps
module modem_handshake_bench;
  logic clk = 1'b0;
  logic rst_n, cts_n_pin, dcd_n_pin, auto_en, async_mode, flag_release_en;
  logic rts_bit, dtr_bit, req_mode, req_delay_sel, tx_empty, flag_done;
  logic tx_dma_req, ie_cts, ie_dcd, status_clr;
  logic tx_enable, rx_enable, rts_n, dtr_req_n, cts_status, dcd_status, status_irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  modem_handshake u_modem_handshake (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", rq, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R13 rts_n", rts_n, 1'b1);
    chk("R13 dtr_req_n", dtr_req_n, 1'b1);
    chk("R13 status_irq", status_irq, 1'b0);
    chk("R13 cts_status", cts_status, 1'b0);
    chk("R13 dcd_status", dcd_status, 1'b0);
  endtask

  task automatic t_enables;
    cts_n_pin = 1'b0; step(3);
    chk("R5 tx_enable auto off", tx_enable, 1'b1);
    cts_n_pin = 1'b1; step(3);
    chk("R5 tx_enable auto off pin high", tx_enable, 1'b1);
    chk("R5 rx_enable auto off", rx_enable, 1'b1);
    auto_en = 1'b1; #1;
    chk("R6 tx_enable gated", tx_enable, 1'b0);
    cts_n_pin = 1'b0; step(1);
    chk("R6 tx_enable not yet", tx_enable, 1'b0);
    step(1);
    chk("R6 tx_enable after sync", tx_enable, 1'b1);
    dcd_n_pin = 1'b0; step(2);
    chk("R6 rx_enable after sync", rx_enable, 1'b1);
    cts_n_pin = 1'b1; dcd_n_pin = 1'b1; step(3);
    chk("R6 tx_enable drop", tx_enable, 1'b0);
    auto_en = 1'b0;
  endtask

  task automatic t_irq;
    ie_cts = 1'b1;
    cts_n_pin = 1'b0; step(2);
    chk("R2 irq not before third edge", status_irq, 1'b0);
    step(1);
    chk("R2 irq on falling pin", status_irq, 1'b1);
    chk("R1 cts_status latched", cts_status, 1'b1);
    cts_n_pin = 1'b1; step(4);
    chk("R2 cts_status frozen", cts_status, 1'b1);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    chk("R4 irq cleared", status_irq, 1'b0);
    chk("R4 status reloaded", cts_status, 1'b0);
    ie_cts = 1'b0; ie_dcd = 1'b1;
    dcd_n_pin = 1'b0; step(3);
    chk("R2 irq on dcd fall", status_irq, 1'b1);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    dcd_n_pin = 1'b1; step(3);
    chk("R2 irq on dcd rise", status_irq, 1'b1);
    chk("R1 dcd_status deasserted", dcd_status, 1'b0);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    ie_dcd = 1'b0;
  endtask

  task automatic t_disabled;
    cts_n_pin = 1'b0; step(4);
    chk("R3 no irq when disabled", status_irq, 1'b0);
    chk("R3 status follows", cts_status, 1'b1);
    cts_n_pin = 1'b1; step(4);
    chk("R3 status follows back", cts_status, 1'b0);
  endtask

  task automatic t_collision;
    ie_cts = 1'b1; ie_dcd = 1'b1;
    dcd_n_pin = 1'b0; step(3);
    chk("R4 setup pending", status_irq, 1'b1);
    cts_n_pin = 1'b0; step(2);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    chk("R4 change beats clear", status_irq, 1'b1);
    chk("R4 new level latched", cts_status, 1'b1);
    status_clr = 1'b1; step(1); status_clr = 1'b0;
    chk("R4 later clear", status_irq, 1'b0);
    ie_cts = 1'b0; ie_dcd = 1'b0;
    cts_n_pin = 1'b1; dcd_n_pin = 1'b1; step(4);
  endtask

  task automatic t_rts;
    rts_bit = 1'b1; step(1);
    chk("R7 rts asserted", rts_n, 1'b0);
    rts_bit = 1'b0; step(1);
    chk("R7 rts released", rts_n, 1'b1);
    auto_en = 1'b1; tx_empty = 1'b0;
    rts_bit = 1'b1; step(1);
    rts_bit = 1'b0; step(3);
    chk("R8 rts held while draining", rts_n, 1'b0);
    tx_empty = 1'b1; step(1);
    chk("R8 rts released when empty", rts_n, 1'b1);
    auto_en = 1'b0; async_mode = 1'b0; flag_release_en = 1'b1;
    rts_bit = 1'b1; step(1);
    rts_bit = 1'b0; step(3);
    chk("R9 rts held until flag out", rts_n, 1'b0);
    flag_done = 1'b1; step(1); flag_done = 1'b0;
    chk("R9 rts released after flag", rts_n, 1'b1);
    async_mode = 1'b1; flag_release_en = 1'b0;
  endtask

  task automatic t_dtr;
    tx_dma_req = 1'b1; step(2);
    chk("R10 dma source ignored", dtr_req_n, 1'b1);
    tx_dma_req = 1'b0;
    dtr_bit = 1'b1; step(1);
    chk("R10 dtr asserted", dtr_req_n, 1'b0);
    dtr_bit = 1'b0; step(1);
    chk("R10 dtr released", dtr_req_n, 1'b1);
    req_mode = 1'b1; dtr_bit = 1'b1;
    tx_dma_req = 1'b1; step(1);
    chk("R11 request asserted", dtr_req_n, 1'b0);
    tx_dma_req = 1'b0; step(1);
    chk("R11 request released at once", dtr_req_n, 1'b1);
    req_delay_sel = 1'b1;
    tx_dma_req = 1'b1; step(1);
    chk("R12 request asserted", dtr_req_n, 1'b0);
    tx_dma_req = 1'b0; step(4);
    chk("R12 request still held", dtr_req_n, 1'b0);
    step(1);
    chk("R12 request released late", dtr_req_n, 1'b1);
    req_mode = 1'b0; req_delay_sel = 1'b0; dtr_bit = 1'b0; step(1);
  endtask

  initial begin
    rst_n = 1'b0; cts_n_pin = 1'b1; dcd_n_pin = 1'b1; auto_en = 1'b0;
    async_mode = 1'b1; flag_release_en = 1'b0; rts_bit = 1'b1; dtr_bit = 1'b1;
    req_mode = 1'b0; req_delay_sel = 1'b0; tx_empty = 1'b0; flag_done = 1'b0;
    tx_dma_req = 1'b0; ie_cts = 1'b0; ie_dcd = 1'b0; status_clr = 1'b0;
    step(3);
    t_reset();
    rts_bit = 1'b0; dtr_bit = 1'b0;
    rst_n = 1'b1; step(2);
    t_enables();
    t_irq();
    t_disabled();
    t_collision();
    t_rts();
    t_dtr();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule